// File: doc/BRIEF.md
# Indirect Register Read Port

This block sits on the host side of a four-channel receive datapath and gives a 16-bit host bus indirect access to per-channel results. The host loads a 16-bit internal address through one direct bus slot. Its top nibble chooses a channel, and its low bits choose one data item. Sample items (I, Q, magnitude and phase) are frozen into a holding register by a one-cycle fetch strobe that follows each address load. The AGC gain item is read live from a per-channel snapshot, so it never needs a fetch.

Results are read as two 16-bit words at two direct addresses, and both words come from the same capture. One internal address register serves both indirect reads and indirect writes. After an indirect write, the host can read the same location back straight away without loading the address again. An indirect write to the AGC item takes a snapshot of one channel's gain, or of all channels at once through the broadcast nibble.

A read of a location that does not exist returns zero and sets a sticky error flag. The host clears that flag with a bus write.

Top module: `ind_read_port`

## Requirements
- R1: A host write to direct address 3 loads the 16-bit shared indirect address, which also appears on `iw_addr` from the next cycle. A host read of direct address 3 returns that address.
- R2: Indirect address layout. Bits 15:12 select the channel: 0 to 3 are valid, and F is also valid (it reads channel 0 and broadcasts AGC capture). Bits 11:3 must be zero. Bits 2:0 select the item: 0 AGC gain, 1 I, 2 Q, 3 magnitude, 4 phase. Codes 5 to 7 are unmapped.
- R3: An address load that names a valid sample item (codes 1 to 4) raises `fetch_stb` for exactly the one cycle after the write. An AGC item or an invalid address raises no strobe.
- R4: The captured value is the item's input during the strobe cycle. Later input changes are not visible until the address is loaded again, which refetches the item.
- R5: For I, Q and magnitude (24 bits), direct address 1 returns bits 23:8 and direct address 0 returns bits 7:0 followed by eight zero bits. For phase, address 0 returns the 16-bit value and address 1 returns zero.
- R6: The AGC item is live. Address 0 returns the channel's gain snapshot, address 1 returns zero, and a snapshot change shows on the next read without reloading the address.
- R7: A host write to direct address 4 while the shared address names a valid AGC item copies `agc_gain` of that channel into its snapshot, or of all four channels when the nibble is F. An immediate read returns the new value.
- R8: A host write to direct address 4 pulses `iw_stb` for one cycle on the next cycle, with `iw_data` equal to the written word and `iw_addr` equal to the shared address.
- R9: A read at direct address 0 or 1 while the address has an invalid channel or is unmapped returns zero and sets `err_sticky`. The flag stays set until a host write to direct address 2, and reading direct address 2 returns it in bit 0.
- R10: `bus_rdata` updates only on the clock edge that ends a read cycle and holds otherwise. After reset all outputs are zero.
- R11: Reads of address 0 and address 1 after one fetch return halves of the same capture, even if the inputs change between the two reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Host write strobe, one cycle per access |
| bus_rd | input | 1 | Host read strobe, one cycle per access |
| bus_addr | input | 3 | Direct address |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Registered host read data |
| err_sticky | output | 1 | Sticky invalid-read flag |
| fetch_stb | output | 1 | One-cycle capture strobe for sample items |
| iw_stb | output | 1 | Indirect write pulse to the datapath |
| iw_addr | output | 16 | Shared indirect address |
| iw_data | output | 16 | Indirect write data |
| smp_i | input | NCH*DW | Per-channel I samples, channel c at bits c*DW |
| smp_q | input | NCH*DW | Per-channel Q samples |
| smp_mag | input | NCH*DW | Per-channel magnitude |
| smp_phase | input | NCH*16 | Per-channel phase |
| agc_gain | input | NCH*16 | Per-channel live AGC gain |

## Verification
Every result has its own latency. `fetch_stb` and `iw_addr` are valid in the cycle right after an address write. The holding register takes its value at the edge that ends the strobe cycle, so a read issued two or more cycles after the write sees the fetched item. `bus_rdata`, `err_sticky` and `iw_stb` change at the edge that closes the read or write cycle. An AGC snapshot changes at the edge that closes the indirect write, so the very next read returns it. The bench drives inputs and samples outputs on the falling edge. It runs a behavioural model that is advanced on each rising edge and compared on each falling edge. Stimulus changes to sample inputs are placed after the capture edge, so the R4 and R11 checks show that no later value leaks through.

// File: rtl/irp_pkg.sv
`timescale 1ns/1ps
package irp_pkg;
    localparam int WORD_W = 16;
    localparam int ADDR_W = 16;
    localparam int DBL_W  = 2 * WORD_W;

    // direct bus slots
    localparam logic [2:0] DA_LO     = 3'd0;
    localparam logic [2:0] DA_HI     = 3'd1;
    localparam logic [2:0] DA_ERRCLR = 3'd2;
    localparam logic [2:0] DA_IADDR  = 3'd3;
    localparam logic [2:0] DA_IWR    = 3'd4;

    localparam logic [3:0] CH_BCAST = 4'hF;

    typedef enum logic [2:0] {
        ITEM_AGC   = 3'd0,
        ITEM_I     = 3'd1,
        ITEM_Q     = 3'd2,
        ITEM_MAG   = 3'd3,
        ITEM_PHASE = 3'd4,
        ITEM_RSV5  = 3'd5,
        ITEM_RSV6  = 3'd6,
        ITEM_RSV7  = 3'd7
    } item_e;

    typedef struct packed {
        logic       valid;
        logic       bcast;
        logic [3:0] chan;
        item_e      item;
        logic       needs_fetch;
    } sel_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DBL_W-1:0]  hold;
        logic [WORD_W-1:0] rdata;
        logic              err;
        logic              fetch_stb;
        logic              iw_stb;
        logic [WORD_W-1:0] iw_data;
    } st_t;

    function automatic sel_t decode_addr(input logic [ADDR_W-1:0] a, input int nch);
        sel_t s;
        logic [3:0] nib;
        logic chan_ok;
        logic item_ok;
        nib           = a[ADDR_W-1 -: 4];
        s.bcast       = (nib == CH_BCAST);
        chan_ok       = s.bcast || (32'(nib) < 32'(nch));
        item_ok       = (a[ADDR_W-5:3] == '0) && (a[2:0] <= 3'd4);
        s.valid       = chan_ok && item_ok;
        s.chan        = s.bcast ? 4'd0 : nib;
        s.item        = item_e'(a[2:0]);
        s.needs_fetch = s.valid && (a[2:0] != 3'd0);
        return s;
    endfunction
endpackage

// File: rtl/irp_sample_mux.sv
`timescale 1ns/1ps
module irp_sample_mux
    import irp_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 24
) (
    input  logic                   sel_valid,
    input  logic [3:0]             sel_chan,
    input  item_e                  sel_item,
    input  logic [NCH*DW-1:0]      smp_i,
    input  logic [NCH*DW-1:0]      smp_q,
    input  logic [NCH*DW-1:0]      smp_mag,
    input  logic [NCH*WORD_W-1:0]  smp_phase,
    input  logic [NCH*WORD_W-1:0]  agc_snap,
    output logic [DBL_W-1:0]       fetch_word,
    output logic [DBL_W-1:0]       live_word
);
    localparam int LO_BITS = DW - WORD_W;
    localparam int PAD     = DBL_W - DW;

    // upper word: top WORD_W bits; lower word: remaining bits left-justified
    function automatic logic [DBL_W-1:0] split_wide(input logic [DW-1:0] v);
        return {v[DW-1 -: WORD_W], v[LO_BITS-1:0], {PAD{1'b0}}};
    endfunction

    always_comb begin
        fetch_word = '0;
        live_word  = '0;
        for (int c = 0; c < NCH; c++) begin
            if (sel_valid && (sel_chan == 4'(c))) begin
                case (sel_item)
                    ITEM_AGC:   live_word  = {{WORD_W{1'b0}}, agc_snap[c*WORD_W +: WORD_W]};
                    ITEM_I:     fetch_word = split_wide(smp_i[c*DW +: DW]);
                    ITEM_Q:     fetch_word = split_wide(smp_q[c*DW +: DW]);
                    ITEM_MAG:   fetch_word = split_wide(smp_mag[c*DW +: DW]);
                    ITEM_PHASE: fetch_word = {{WORD_W{1'b0}}, smp_phase[c*WORD_W +: WORD_W]};
                    default:    ;
                endcase
            end
        end
    end
endmodule

// File: rtl/irp_agc_bank.sv
`timescale 1ns/1ps
module irp_agc_bank
    import irp_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cap_en,
    input  logic                  cap_all,
    input  logic [3:0]            cap_chan,
    input  logic [NCH*WORD_W-1:0] agc_gain,
    output logic [NCH*WORD_W-1:0] snap
);
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic [WORD_W-1:0] snap_d;
        logic [WORD_W-1:0] snap_q;
        logic              take;

        assign take = cap_en && (cap_all || (cap_chan == 4'(g)));

        always_comb begin
            snap_d = snap_q;
            if (take) begin
                snap_d = agc_gain[g*WORD_W +: WORD_W];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) snap_q <= '0;
            else        snap_q <= snap_d;
        end

        assign snap[g*WORD_W +: WORD_W] = snap_q;
    end
endmodule

// File: rtl/ind_read_port.sv
`timescale 1ns/1ps
module ind_read_port
    import irp_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 24
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    input  logic [2:0]             bus_addr,
    input  logic [15:0]            bus_wdata,
    output logic [15:0]            bus_rdata,
    output logic                   err_sticky,
    output logic                   fetch_stb,
    output logic                   iw_stb,
    output logic [15:0]            iw_addr,
    output logic [15:0]            iw_data,
    input  logic [NCH*DW-1:0]      smp_i,
    input  logic [NCH*DW-1:0]      smp_q,
    input  logic [NCH*DW-1:0]      smp_mag,
    input  logic [NCH*16-1:0]      smp_phase,
    input  logic [NCH*16-1:0]      agc_gain
);
    st_t                  s_d, s_q;
    sel_t                 cur_sel;
    logic                 wr_fetch;
    logic                 agc_cap;
    logic [DBL_W-1:0]     fetch_word;
    logic [DBL_W-1:0]     live_word;
    logic [DBL_W-1:0]     word;
    logic [NCH*WORD_W-1:0] agc_snap;

    assign cur_sel  = decode_addr(s_q.addr, NCH);
    assign wr_fetch = decode_addr(bus_wdata, NCH).needs_fetch;

    irp_sample_mux #(.NCH(NCH), .DW(DW)) u_mux (
        .sel_valid  (cur_sel.valid),
        .sel_chan   (cur_sel.chan),
        .sel_item   (cur_sel.item),
        .smp_i      (smp_i),
        .smp_q      (smp_q),
        .smp_mag    (smp_mag),
        .smp_phase  (smp_phase),
        .agc_snap   (agc_snap),
        .fetch_word (fetch_word),
        .live_word  (live_word)
    );

    irp_agc_bank #(.NCH(NCH)) u_agc (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (agc_cap),
        .cap_all  (cur_sel.bcast),
        .cap_chan (cur_sel.chan),
        .agc_gain (agc_gain),
        .snap     (agc_snap)
    );

    always_comb begin
        s_d           = s_q;
        s_d.fetch_stb = 1'b0;
        s_d.iw_stb    = 1'b0;
        agc_cap       = 1'b0;
        word          = '0;

        // capture at the end of the strobe cycle
        if (s_q.fetch_stb) begin
            s_d.hold = fetch_word;
        end

        if (bus_wr) begin
            case (bus_addr)
                DA_IADDR: begin
                    s_d.addr      = bus_wdata;
                    s_d.fetch_stb = wr_fetch;
                end
                DA_ERRCLR: s_d.err = 1'b0;
                DA_IWR: begin
                    s_d.iw_stb  = 1'b1;
                    s_d.iw_data = bus_wdata;
                    agc_cap     = cur_sel.valid && (cur_sel.item == ITEM_AGC);
                end
                default: ;
            endcase
        end else if (bus_rd) begin
            case (bus_addr)
                DA_LO, DA_HI: begin
                    if (!cur_sel.valid) begin
                        s_d.rdata = '0;
                        s_d.err   = 1'b1;
                    end else begin
                        word      = cur_sel.needs_fetch ? s_q.hold : live_word;
                        s_d.rdata = (bus_addr == DA_LO) ? word[WORD_W-1:0] : word[DBL_W-1:WORD_W];
                    end
                end
                DA_ERRCLR: s_d.rdata = {{(WORD_W-1){1'b0}}, s_q.err};
                DA_IADDR:  s_d.rdata = s_q.addr;
                default:   s_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bus_rdata  = s_q.rdata;
    assign err_sticky = s_q.err;
    assign fetch_stb  = s_q.fetch_stb;
    assign iw_stb     = s_q.iw_stb;
    assign iw_addr    = s_q.addr;
    assign iw_data    = s_q.iw_data;
endmodule

module irp_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [2:0]  bus_addr,
    input logic [15:0] bus_wdata,
    input logic [15:0] bus_rdata,
    input logic        err_sticky,
    input logic        fetch_stb,
    input logic        iw_stb,
    input logic [15:0] iw_addr,
    input logic [15:0] iw_data
);
    // R1
    addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd3) |=> (iw_addr == $past(bus_wdata)));

    // R1
    addr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == 3'd3) |=> $stable(iw_addr));

    // R3
    fetch_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_stb |-> $past(bus_wr && bus_addr == 3'd3));

    // R3
    fetch_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_stb && !(bus_wr && bus_addr == 3'd3)) |=> !fetch_stb);

    // R8
    iw_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iw_stb |-> ($past(bus_wr && bus_addr == 3'd4) && iw_data == $past(bus_wdata)));

    // R9
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_sticky && !(bus_wr && bus_addr == 3'd2)) |=> err_sticky);

    // R9
    err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_sticky) |-> ($past(bus_rd) && bus_rdata == 16'h0000));

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

bind ind_read_port irp_checker u_chk (.*);

// File: tb/ind_read_port_test.sv
`timescale 1ns/1ps
module ind_read_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        err_sticky, fetch_stb, iw_stb;
    logic [15:0] iw_addr, iw_data;
    logic [95:0] smp_i, smp_q, smp_mag;
    logic [63:0] smp_phase, agc_gain;

    logic [23:0] ti [4];
    logic [23:0] tq [4];
    logic [23:0] tm [4];
    logic [15:0] tp [4];
    logic [15:0] tg [4];

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    always_comb begin
        for (int c = 0; c < 4; c++) begin
            smp_i[c*24 +: 24]     = ti[c];
            smp_q[c*24 +: 24]     = tq[c];
            smp_mag[c*24 +: 24]   = tm[c];
            smp_phase[c*16 +: 16] = tp[c];
            agc_gain[c*16 +: 16]  = tg[c];
        end
    end

    ind_read_port uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .err_sticky(err_sticky), .fetch_stb(fetch_stb), .iw_stb(iw_stb),
        .iw_addr(iw_addr), .iw_data(iw_data), .smp_i(smp_i), .smp_q(smp_q),
        .smp_mag(smp_mag), .smp_phase(smp_phase), .agc_gain(agc_gain)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [15:0] m_addr, m_rdata, m_iwdata;
    logic [31:0] m_hold;
    logic        m_fstb, m_err, m_iwstb;
    logic [15:0] m_agc [4];

    function automatic bit addr_ok(input logic [15:0] a);
        int nib = int'(a[15:12]);
        return ((nib < 4) || (nib == 15)) && (a[11:3] == 9'd0) && (int'(a[2:0]) <= 4);
    endfunction

    function automatic int chan_of(input logic [15:0] a);
        return (a[15:12] == 4'hF) ? 0 : int'(a[15:12]);
    endfunction

    function automatic logic [31:0] wide_words(input logic [23:0] v);
        logic [31:0] x = {8'h00, v};
        return ((x >> 8) << 16) | ((x & 32'hFF) << 8);
    endfunction

    function automatic logic [31:0] item_word(input logic [15:0] a);
        int c = chan_of(a);
        case (int'(a[2:0]))
            1: return wide_words(ti[c]);
            2: return wide_words(tq[c]);
            3: return wide_words(tm[c]);
            4: return {16'h0000, tp[c]};
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin : model
        logic [31:0] w;
        if (!rst_n) begin
            m_addr = 0; m_rdata = 0; m_iwdata = 0; m_hold = 0;
            m_fstb = 0; m_err = 0; m_iwstb = 0;
            for (int c = 0; c < 4; c++) m_agc[c] = 0;
        end else begin
            if (m_fstb && addr_ok(m_addr)) m_hold = item_word(m_addr);
            m_fstb  = 0;
            m_iwstb = 0;
            if (bus_wr) begin
                if (bus_addr == 3) begin
                    m_addr = bus_wdata;
                    m_fstb = addr_ok(bus_wdata) && (bus_wdata[2:0] != 0);
                end else if (bus_addr == 2) begin
                    m_err = 0;
                end else if (bus_addr == 4) begin
                    m_iwstb  = 1;
                    m_iwdata = bus_wdata;
                    if (addr_ok(m_addr) && m_addr[2:0] == 0)
                        for (int c = 0; c < 4; c++)
                            if (m_addr[15:12] == 4'hF || int'(m_addr[15:12]) == c) m_agc[c] = tg[c];
                end
            end else if (bus_rd) begin
                if (bus_addr <= 1) begin
                    if (!addr_ok(m_addr)) begin
                        m_rdata = 0; m_err = 1;
                    end else begin
                        w = (m_addr[2:0] == 0) ? {16'h0, m_agc[chan_of(m_addr)]} : m_hold;
                        m_rdata = (bus_addr == 0) ? w[15:0] : w[31:16];
                    end
                end else if (bus_addr == 2) m_rdata = {15'h0, m_err};
                else if (bus_addr == 3)     m_rdata = m_addr;
                else                        m_rdata = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(bus_rdata == m_rdata,  "R10 model rdata", {16'h0, bus_rdata}, {16'h0, m_rdata});
            chk(err_sticky == m_err,   "R9 model err", {31'h0, err_sticky}, {31'h0, m_err});
            chk(fetch_stb == m_fstb,   "R3 model fetch", {31'h0, fetch_stb}, {31'h0, m_fstb});
            chk(iw_stb == m_iwstb,     "R8 model iw_stb", {31'h0, iw_stb}, {31'h0, m_iwstb});
            chk(iw_addr == m_addr,     "R1 model addr", {16'h0, iw_addr}, {16'h0, m_addr});
            chk(iw_data == m_iwdata,   "R8 model iw_data", {16'h0, iw_data}, {16'h0, m_iwdata});
        end
    end

    // ---------------- stimulus ----------------
    task automatic bwrite(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bread(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        logic [15:0] v2;
        for (int c = 0; c < 4; c++) begin
            ti[c] = 24'h100000 * (c + 1) + 24'h000111;
            tq[c] = 24'h0A0000 + 24'h000202 * c;
            tm[c] = 24'hF00000 - 24'h001000 * c;
            tp[c] = 16'h0500 + 16'(c);
            tg[c] = 16'h7000 + 16'(c);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(bus_rdata == 0 && err_sticky == 0 && fetch_stb == 0 && iw_stb == 0 && iw_addr == 0,
            "R10 reset", {bus_rdata, iw_addr}, 32'h0);

        // R3/R4/R5/R11: fetch I of channel 2
        ti[2] = 24'hABCDEF;
        bwrite(3'd3, 16'h2001);
        chk(fetch_stb == 1'b1, "R3 strobe after write", {31'h0, fetch_stb}, 32'h1);
        @(negedge clk);
        chk(fetch_stb == 1'b0, "R3 strobe one wide", {31'h0, fetch_stb}, 32'h0);
        ti[2] = 24'h123456;
        bread(3'd1, v);
        chk(v == 16'hABCD, "R5 I upper word", {16'h0, v}, 32'hABCD);
        ti[2] = 24'h654321;
        bread(3'd0, v);
        chk(v == 16'hEF00, "R11 I lower word same capture", {16'h0, v}, 32'hEF00);
        chk(v == 16'hEF00, "R4 held despite input change", {16'h0, v}, 32'hEF00);

        // R4 refetch after rewriting the address
        bwrite(3'd3, 16'h2001);
        @(negedge clk);
        bread(3'd1, v);
        chk(v == 16'h6543, "R4 refetch", {16'h0, v}, 32'h6543);

        // R5 phase, Q, magnitude
        tp[1] = 16'h1234;
        bwrite(3'd3, 16'h1004);
        @(negedge clk);
        bread(3'd0, v);
        bread(3'd1, v2);
        chk(v == 16'h1234 && v2 == 16'h0000, "R5 phase words", {v2, v}, 32'h00001234);
        tq[3] = 24'h00FF80;
        bwrite(3'd3, 16'h3002);
        @(negedge clk);
        bread(3'd0, v);
        bread(3'd1, v2);
        chk(v == 16'h8000 && v2 == 16'h00FF, "R5 Q words", {v2, v}, 32'h00FF8000);
        tm[0] = 24'h800001;
        bwrite(3'd3, 16'h0003);
        @(negedge clk);
        bread(3'd1, v);
        bread(3'd0, v2);
        chk(v == 16'h8000 && v2 == 16'h0100, "R5 magnitude words", {v, v2}, 32'h80000100);

        // R2 broadcast nibble reads channel 0
        ti[0] = 24'h13579B;
        bwrite(3'd3, 16'hF001);
        @(negedge clk);
        bread(3'd1, v);
        chk(v == 16'h1357, "R2 nibble F reads channel 0", {16'h0, v}, 32'h1357);

        // R6/R7 AGC item: no strobe, live snapshot
        tg[0] = 16'h1111;
        bwrite(3'd3, 16'h0000);
        chk(fetch_stb == 1'b0, "R3 no strobe for AGC", {31'h0, fetch_stb}, 32'h0);
        bread(3'd0, v);
        chk(v == 16'h0000, "R6 snapshot before capture", {16'h0, v}, 32'h0);
        bwrite(3'd4, 16'hBEEF);
        chk(iw_stb == 1'b1 && iw_data == 16'hBEEF && iw_addr == 16'h0000, "R8 indirect write pulse",
            {iw_data, iw_addr}, 32'hBEEF0000);
        bread(3'd0, v);
        chk(v == 16'h1111, "R7 readback after indirect write", {16'h0, v}, 32'h1111);
        tg[0] = 16'h2222;
        bread(3'd0, v);
        bread(3'd1, v2);
        chk(v == 16'h1111 && v2 == 16'h0, "R6 snapshot not live input", {v2, v}, 32'h00001111);
        bwrite(3'd4, 16'h0001);
        bread(3'd0, v);
        chk(v == 16'h2222, "R6 change visible without address rewrite", {16'h0, v}, 32'h2222);

        // R7 broadcast capture
        for (int c = 0; c < 4; c++) tg[c] = 16'hC000 + 16'(c);
        bwrite(3'd3, 16'hF000);
        bwrite(3'd4, 16'h0000);
        bwrite(3'd3, 16'h3000);
        bread(3'd0, v);
        chk(v == 16'hC003, "R7 broadcast channel 3", {16'h0, v}, 32'hC003);
        bwrite(3'd3, 16'h1000);
        bread(3'd0, v);
        chk(v == 16'hC001, "R7 broadcast channel 1", {16'h0, v}, 32'hC001);

        // R7 single-channel capture leaves others alone
        tg[1] = 16'h0BAD; tg[2] = 16'h0DAD;
        bwrite(3'd3, 16'h2000);
        bwrite(3'd4, 16'h0000);
        bwrite(3'd3, 16'h1000);
        bread(3'd0, v);
        chk(v == 16'hC001, "R7 other channel untouched", {16'h0, v}, 32'hC001);

        // R9 invalid channel and unmapped items
        bwrite(3'd3, 16'h5001);
        chk(fetch_stb == 1'b0, "R3 no strobe for invalid channel", {31'h0, fetch_stb}, 32'h0);
        bread(3'd0, v);
        chk(v == 16'h0 && err_sticky == 1'b1, "R9 invalid channel read", {15'h0, err_sticky, v}, 32'h10000);
        bwrite(3'd3, 16'h0001);
        @(negedge clk);
        bread(3'd1, v);
        chk(err_sticky == 1'b1, "R9 flag sticky over valid read", {31'h0, err_sticky}, 32'h1);
        bread(3'd2, v);
        chk(v == 16'h0001, "R9 flag readable", {16'h0, v}, 32'h1);
        bwrite(3'd2, 16'h0000);
        chk(err_sticky == 1'b0, "R9 flag cleared", {31'h0, err_sticky}, 32'h0);
        bwrite(3'd3, 16'h0005);
        bread(3'd1, v);
        chk(v == 16'h0 && err_sticky == 1'b1, "R2 item code 5 unmapped", {15'h0, err_sticky, v}, 32'h10000);
        bwrite(3'd2, 16'h0000);
        bwrite(3'd3, 16'h0101);
        bread(3'd0, v);
        chk(err_sticky == 1'b1, "R2 middle bits must be zero", {31'h0, err_sticky}, 32'h1);
        bwrite(3'd2, 16'h0000);

        // R1 address readback
        bwrite(3'd3, 16'h2004);
        bread(3'd3, v);
        chk(v == 16'h2004, "R1 address readback", {16'h0, v}, 32'h2004);

        // R10 output held while idle
        tp[2] = 16'h4242;
        repeat (4) @(negedge clk);
        chk(bus_rdata == 16'h2004, "R10 rdata held", {16'h0, bus_rdata}, 32'h2004);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule